// File: doc/BRIEF.md
# Associative Time-Slot Connection Memory

This block is the switching core of a time-slot interchanger. Each incoming time slot is identified by a 13-bit stream/slot address. The core does not index a per-slot table. It searches a content-addressable connection store for an entry that names that address, and the entry says what to do with the slot. Each entry carries a tag that points into a shared byte store.

There are three banks of connection entries: one for even bus streams, one for odd bus streams and one for local streams. Each bank has 256 entries by default. The bank searched is chosen from the address itself. A simplex connection is built from two entries that carry the same tag:
- a capture entry on the source address, which stores the slot's byte at the tagged location;
- a replay entry on the destination address, which drives the stored byte out.

Several replay entries can share one tag, which gives broadcast. A replay entry in pattern mode drives its own tag as the output byte. The byte store is split into two buffers, and each entry selects one of them.

A host port writes whole entries, addressed by bank and index.

Top module: `tsi_cam_switch`

## Requirements
- R1: After reset, every entry is invalid and `out_hit`, `out_valid`, `out_bank`, `out_idx` and `out_data` are all zero. A lookup made before any entry is programmed misses.
- R2: The bank searched is chosen from `lk_addr`:
  - bank 2 (local) when bits [12:11] are 2'b11;
  - otherwise bank 0 (even) when bit 0 is 0, and bank 1 (odd) when bit 0 is 1.
  Only the chosen bank is searched.
- R3: An entry matches when it is valid and its address equals `lk_addr`. The outputs are registered: a lookup sampled at clock edge k shows its result (`out_hit`, the bank on `out_bank`, the entry index on `out_idx`) right after edge k. When `lk_valid` is low, `out_hit` is low.
- R4: When several entries in the searched bank match, the entry with the lowest index is used.
- R5: A matching capture entry (read flag 0) stores `lk_data` at location `tag` of the buffer the entry selects. The store happens at the sampling edge. `out_valid` stays low for a capture hit.
- R6: A matching replay entry (read flag 1, pattern flag 0) raises `out_valid` and drives the byte held at location `tag` of the buffer the entry selects.
- R7: A matching replay entry with the pattern flag set drives its own 8-bit tag on `out_data`.
- R8: Buffer 0 (select 0) and buffer 1 (select 1) are independent. A capture into one buffer leaves the other buffer's bytes unchanged.
- R9: Several replay entries that share one tag and one buffer all output the same stored byte (broadcast).
- R10: A host write with the valid flag clear removes the entry. A host write to bank code 3 has no effect on any bank.
- R11: `out_data` is zero whenever `out_valid` is low.
- R12: A lookup in the same cycle as a host write to the matching entry uses the entry as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host entry write strobe |
| cfg_bank | input | 2 | Target bank (0 even, 1 odd, 2 local; 3 ignored) |
| cfg_idx | input | 8 | Entry index within the bank |
| cfg_valid | input | 1 | Entry valid flag |
| cfg_read | input | 1 | 1 = replay entry, 0 = capture entry |
| cfg_pattern | input | 1 | Pattern mode for replay entries |
| cfg_buf | input | 1 | Byte buffer select |
| cfg_addr | input | 13 | Stream/slot address the entry matches |
| cfg_tag | input | 8 | Byte-store location, or pattern byte |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 13 | Stream/slot address presented |
| lk_data | input | 8 | Slot byte offered for capture |
| out_hit | output | 1 | Registered: the lookup matched an entry |
| out_bank | output | 2 | Registered: bank that was searched |
| out_idx | output | 8 | Registered: index of the winning entry |
| out_valid | output | 1 | Registered: a replay byte is on out_data |
| out_data | output | 8 | Registered: replayed byte |

## Verification
On every cycle, the assertions check these properties:
- a replay byte never appears without a hit;
- `out_data` is zero while nothing is replayed;
- a hit never reports bank code 3;
- a hit reports the bank that the sampled address routes to;
- no hit follows a cycle with no lookup.

Other behaviour can only be seen through the bench's scenarios. This covers lowest-index priority, capture-then-replay through the byte store, pattern output, buffer independence, broadcast, entry removal, ignored bank code 3 and old-entry use on a same-cycle host write. These are checked against a reference model of the entries and buffers kept in the bench.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int ADDR_W = 13;
    localparam int TAG_W  = 8;
    localparam int NBANK  = 3;

    typedef enum logic [1:0] {
        BANK_EVEN  = 2'd0,
        BANK_ODD   = 2'd1,
        BANK_LOCAL = 2'd2
    } bank_e;

    typedef struct packed {
        logic              valid;
        logic              is_read;
        logic              pattern;
        logic              buf_sel;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } conn_t;

    // Local streams occupy the top quarter of the address space;
    // bus streams split on the low bit.
    function automatic bank_e route_bank(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1 -: 2] == 2'b11) return BANK_LOCAL;
        else if (a[0])                 return BANK_ODD;
        else                           return BANK_EVEN;
    endfunction

endpackage

// File: rtl/cam_bank.sv
module cam_bank
    import tsi_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  conn_t             wr_entry,
    input  logic [ADDR_W-1:0] key,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output conn_t             hit_entry
);

    conn_t              tbl [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_entry;
        end
    end

    // Parallel compare against every stored entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl[g].valid && (tbl[g].addr == key);
    end

    // Priority pick: scanning downward, the last match seen is the lowest index.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_entry = tbl[hit_idx];
    end

endmodule

// File: rtl/slot_store.sv
module slot_store
    import tsi_pkg::*;
#(
    localparam int DEPTH = 2 ** TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             wsel,
    input  logic [TAG_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic             rsel,
    input  logic [TAG_W-1:0] raddr,
    output logic [7:0]       rdata
);

    logic [7:0] buf0 [DEPTH];
    logic [7:0] buf1 [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                buf0[i] <= '0;
                buf1[i] <= '0;
            end
        end else if (we) begin
            if (wsel) buf1[waddr] <= wdata;
            else      buf0[waddr] <= wdata;
        end
    end

    // Combinational read: sees contents from before the current edge's write.
    assign rdata = rsel ? buf1[raddr] : buf0[raddr];

endmodule

// File: rtl/tsi_cam_switch.sv
module tsi_cam_switch
    import tsi_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_bank,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_valid,
    input  logic              cfg_read,
    input  logic              cfg_pattern,
    input  logic              cfg_buf,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [TAG_W-1:0]  cfg_tag,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [7:0]        lk_data,
    output logic              out_hit,
    output logic [1:0]        out_bank,
    output logic [IDX_W-1:0]  out_idx,
    output logic              out_valid,
    output logic [7:0]        out_data
);

    conn_t            new_entry;
    logic             b_hit [NBANK];
    logic [IDX_W-1:0] b_idx [NBANK];
    conn_t            b_ent [NBANK];

    bank_e            sel_bank;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;
    conn_t            win;
    logic             cap_we;
    logic [7:0]       store_q;

    assign new_entry = '{valid:   cfg_valid,
                         is_read: cfg_read,
                         pattern: cfg_pattern,
                         buf_sel: cfg_buf,
                         addr:    cfg_addr,
                         tag:     cfg_tag};

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        cam_bank #(.ENTRIES(ENTRIES)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (cfg_we && (cfg_bank == 2'(b))),
            .wr_idx    (cfg_idx),
            .wr_entry  (new_entry),
            .key       (lk_addr),
            .hit       (b_hit[b]),
            .hit_idx   (b_idx[b]),
            .hit_entry (b_ent[b])
        );
    end

    always_comb begin
        sel_bank = route_bank(lk_addr);
        any_hit  = lk_valid && b_hit[sel_bank];
        win_idx  = b_idx[sel_bank];
        win      = b_ent[sel_bank];
        cap_we   = any_hit && !win.is_read;
    end

    slot_store u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (cap_we),
        .wsel  (win.buf_sel),
        .waddr (win.tag),
        .wdata (lk_data),
        .rsel  (win.buf_sel),
        .raddr (win.tag),
        .rdata (store_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_hit   <= 1'b0;
            out_bank  <= '0;
            out_idx   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_hit   <= any_hit;
            out_bank  <= any_hit ? sel_bank : 2'd0;
            out_idx   <= any_hit ? win_idx : '0;
            out_valid <= any_hit && win.is_read;
            if (any_hit && win.is_read)
                out_data <= win.pattern ? win.tag : store_q;
            else
                out_data <= '0;
        end
    end

endmodule

// File: rtl/tsi_cam_switch_chk.sv
module tsi_cam_switch_chk (
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [12:0] lk_addr,
    input logic        out_hit,
    input logic [1:0]  out_bank,
    input logic        out_valid,
    input logic [7:0]  out_data
);

    p_valid_needs_hit_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_hit);

    p_zero_when_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == 8'd0));

    p_no_hit_without_lookup_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !out_hit);

    p_bank_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> (out_bank != 2'd3));

    p_local_route_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_addr[12:11] == 2'b11) |=> (!out_hit || out_bank == 2'd2));

    p_bus_route_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_addr[12:11] != 2'b11) |=> (!out_hit || out_bank == {1'b0, $past(lk_addr[0])}));

endmodule

bind tsi_cam_switch tsi_cam_switch_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .out_hit   (out_hit),
    .out_bank  (out_bank),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_tsi_cam_switch.sv
module tb_tsi_cam_switch;
    import tsi_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_valid, cfg_read, cfg_pattern, cfg_buf;
    logic [1:0]  cfg_bank;
    logic [7:0]  cfg_idx, cfg_tag;
    logic [12:0] cfg_addr;
    logic        lk_valid;
    logic [12:0] lk_addr;
    logic [7:0]  lk_data;
    logic        out_hit, out_valid;
    logic [1:0]  out_bank;
    logic [7:0]  out_idx, out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model
    conn_t      m_tbl [3][256];
    logic [7:0] m_mem [2][256];

    always #4 clk = ~clk;

    tsi_cam_switch dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx),
        .cfg_valid(cfg_valid), .cfg_read(cfg_read), .cfg_pattern(cfg_pattern),
        .cfg_buf(cfg_buf), .cfg_addr(cfg_addr), .cfg_tag(cfg_tag),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_data(lk_data),
        .out_hit(out_hit), .out_bank(out_bank), .out_idx(out_idx),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic conn_t mk(bit v, bit rd, bit pat, bit bs, logic [12:0] a, logic [7:0] t);
        conn_t e;
        e.valid = v; e.is_read = rd; e.pattern = pat; e.buf_sel = bs; e.addr = a; e.tag = t;
        return e;
    endfunction

    function automatic int exp_bank(logic [12:0] a);
        if (a[12] && a[11]) return 2;
        return a[0] ? 1 : 0;
    endfunction

    task automatic chk(string lbl, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", lbl, what, act, exp);
        end
    endtask

    task automatic step(bit c_en, logic [1:0] c_bank, logic [7:0] c_idx, conn_t c_ent,
                        bit l_en, logic [12:0] l_addr, logic [7:0] l_data, string lbl);
        int  b, win;
        bit  e_hit, e_val;
        int  e_data;
        @(negedge clk);
        cfg_we = c_en; cfg_bank = c_bank; cfg_idx = c_idx;
        cfg_valid = c_ent.valid; cfg_read = c_ent.is_read; cfg_pattern = c_ent.pattern;
        cfg_buf = c_ent.buf_sel; cfg_addr = c_ent.addr; cfg_tag = c_ent.tag;
        lk_valid = l_en; lk_addr = l_addr; lk_data = l_data;
        // Expected result from entries as they stand before this edge (R12)
        b = exp_bank(l_addr);
        win = -1;
        for (int i = 255; i >= 0; i--)
            if (m_tbl[b][i].valid && m_tbl[b][i].addr == l_addr) win = i;
        e_hit  = l_en && (win >= 0);
        e_val  = e_hit && m_tbl[b][win].is_read;
        e_data = 0;
        if (e_val)
            e_data = m_tbl[b][win].pattern ? int'(m_tbl[b][win].tag)
                   : int'(m_mem[m_tbl[b][win].buf_sel][m_tbl[b][win].tag]);
        @(posedge clk);
        #1;
        chk(lbl, "out_hit", int'(out_hit), int'(e_hit));
        chk(lbl, "out_valid", int'(out_valid), int'(e_val));
        chk(lbl, "out_data R11", int'(out_data), e_data);
        if (e_hit) begin
            chk(lbl, "out_bank R2", int'(out_bank), b);
            chk(lbl, "out_idx R4", int'(out_idx), win);
        end
        if (e_hit && !m_tbl[b][win].is_read)
            m_mem[m_tbl[b][win].buf_sel][m_tbl[b][win].tag] = l_data;
        if (c_en && c_bank != 2'd3) m_tbl[c_bank][c_idx] = c_ent;
    endtask

    task automatic prog(int bk, int idx, conn_t e, string lbl);
        step(1, 2'(bk), 8'(idx), e, 0, '0, '0, lbl);
    endtask

    task automatic look(logic [12:0] a, logic [7:0] d, string lbl);
        step(0, 2'd0, 8'd0, '0, 1, a, d, lbl);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 256; i++) m_tbl[b][i] = '0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 256; i++) m_mem[s][i] = '0;
        cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_valid = 0; cfg_read = 0;
        cfg_pattern = 0; cfg_buf = 0; cfg_addr = 0; cfg_tag = 0;
        lk_valid = 0; lk_addr = 0; lk_data = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "out_hit", int'(out_hit), 0);
        chk("R1", "out_valid", int'(out_valid), 0);
        chk("R1", "out_data", int'(out_data), 0);
        chk("R1", "out_idx", int'(out_idx), 0);
        @(negedge clk); rst = 0;
        look(13'd2, 8'h11, "R1");
        chk("R1", "miss after reset", int'(out_hit), 0);

        // R5/R6: capture on even addr 2, replay on odd addr 3
        prog(0, 5, mk(1, 0, 0, 0, 13'd2, 8'h10), "R5");
        prog(1, 3, mk(1, 1, 0, 0, 13'd3, 8'h10), "R6");
        look(13'd2, 8'hA5, "R5");
        chk("R5", "capture no valid", int'(out_valid), 0);
        look(13'd3, 8'h00, "R6");
        chk("R6", "replayed byte", int'(out_data), 8'hA5);
        // R2: same address in the wrong bank is never searched
        prog(0, 0, mk(1, 1, 1, 0, 13'd3, 8'hEE), "R2");
        look(13'd3, 8'h00, "R2");
        chk("R2", "odd bank used", int'(out_bank), 1);
        // R4/R7: higher-index pattern entry hidden until lower one removed (R10)
        prog(1, 9, mk(1, 1, 1, 0, 13'd3, 8'h77), "R4");
        look(13'd3, 8'h00, "R4");
        chk("R4", "lowest index", int'(out_idx), 3);
        prog(1, 3, mk(0, 1, 0, 0, 13'd3, 8'h10), "R10");
        look(13'd3, 8'h00, "R7");
        chk("R7", "pattern byte", int'(out_data), 8'h77);
        // R8: capture into buffer 1 at same tag leaves buffer 0 alone
        prog(2, 1, mk(1, 0, 0, 1, 13'h1805, 8'h10), "R8");
        prog(2, 2, mk(1, 1, 0, 1, 13'h1806, 8'h10), "R8");
        prog(0, 6, mk(1, 1, 0, 0, 13'd4, 8'h10), "R8");
        look(13'h1805, 8'h3C, "R8");
        look(13'h1806, 8'h00, "R8");
        chk("R8", "buffer 1 byte", int'(out_data), 8'h3C);
        look(13'd4, 8'h00, "R8");
        chk("R8", "buffer 0 kept", int'(out_data), 8'hA5);
        // R9: broadcast
        prog(1, 20, mk(1, 1, 0, 0, 13'd5, 8'h10), "R9");
        prog(1, 21, mk(1, 1, 0, 0, 13'd7, 8'h10), "R9");
        look(13'd5, 8'h00, "R9");
        chk("R9", "dest a", int'(out_data), 8'hA5);
        look(13'd7, 8'h00, "R9");
        chk("R9", "dest b", int'(out_data), 8'hA5);
        // R10: bank code 3 ignored
        step(1, 2'd3, 8'd20, mk(0, 0, 0, 0, 13'd5, 8'h00), 0, '0, '0, "R10");
        look(13'd5, 8'h00, "R10");
        chk("R10", "bank3 ignored", int'(out_valid), 1);
        // R12: same-cycle host write does not affect this lookup
        step(1, 2'd1, 8'd20, mk(0, 0, 0, 0, 13'd5, 8'h00), 1, 13'd5, 8'h00, "R12");
        chk("R12", "old entry used", int'(out_hit), 1);
        look(13'd5, 8'h00, "R12");
        chk("R12", "removed afterwards", int'(out_hit), 0);

        // Constrained random over a small address/index space
        for (int n = 0; n < 4000; n++) begin
            logic [12:0] ra, la;
            ra = 13'($urandom_range(0, 5)) | ($urandom_range(0, 1) ? 13'h1800 : 13'h0);
            la = 13'($urandom_range(0, 5)) | ($urandom_range(0, 1) ? 13'h1800 : 13'h0);
            step($urandom_range(0, 3) == 0, 2'($urandom_range(0, 3)), 8'($urandom_range(0, 7)),
                 mk($urandom_range(0, 4) != 0, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                    1'($urandom), ra, 8'($urandom_range(0, 3))),
                 $urandom_range(0, 4) != 0, la, 8'($urandom), "R3");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule